// File: doc/BRIEF.md
# Processor interrupt acknowledge sequencer

This block is the interrupt front end of a small 8-bit processor core. It watches five request inputs: one general maskable request, three vectored maskable requests and one non-maskable trap. At every instruction boundary, marked by a timing strobe one clock before the final T-state, it decides whether an interrupt is taken. Maskable sources only count while an interrupt-enable flip-flop is set. The enable-interrupts and disable-interrupts instruction strobes set and clear that flip-flop. Taking any interrupt also clears it.

When the general request wins, the block raises an acknowledge strobe for one cycle and captures a restart opcode from the data bus. The opcode has the form 11NNN111, and the target address is N times 8. When a vectored request or the trap wins, the bus is not read and a fixed address is used. In both cases the block ends with a one-cycle push request: the core saves the address of the next instruction on its stack and jumps to the presented vector.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset the enable flip-flop is clear, `ack_o`, `push_req` and `op_err` are low, and any edge latched on the highest vectored input or the trap input is forgotten.
- R2: A pulse on `ei_stb` sets `int_en` at the next clock. A pulse on `di_stb` clears it at the next clock. When both pulse in the same cycle, `di_stb` wins.
- R3: While `int_en` is low, the general and vectored requests are ignored. The trap is taken whatever the state of `int_en`.
- R4: Requests are evaluated only in a cycle where `slot_end` is high and no sequence is running. Taking an interrupt clears `int_en` at the next clock.
- R5: When the general request wins, `ack_o` is high for exactly the one cycle after the `slot_end` cycle. `data_in` is captured at the end of that cycle. `push_req` is high in the following cycle, with `vec_addr` equal to the bus value's bits 5:3 times 8.
- R6: If the captured byte does not have bits 7:6 = 11 and bits 2:0 = 111, `vec_addr` is 0x0038 and `op_err` is high only during that `push_req` cycle.
- R7: When the trap or a vectored request wins, `ack_o` stays low. `push_req` is high in the cycle after `slot_end`, with `vec_addr` equal to 0x0024 for the trap, 0x003C for `req_vhi`, 0x0034 for `req_vmid` and 0x002C for `req_vlo`.
- R8: Priority is fixed, from highest to lowest: trap, `req_vhi`, `req_vmid`, `req_vlo`, `req_gen`.
- R9: A rising edge on `req_vhi` is stored and kept, even after the line falls, until that source is serviced. Servicing it clears the stored edge.
- R10: The trap is taken only if a rising edge was seen and the line is still high at the boundary. A line that stays high without a new edge is not taken a second time.
- R11: `push_req` is a single-cycle pulse. No new interrupt is taken while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_gen | input | 1 | General maskable request, serviced via the bus opcode |
| req_vlo | input | 1 | Lowest-priority vectored request, level sensitive |
| req_vmid | input | 1 | Middle vectored request, level sensitive |
| req_vhi | input | 1 | Highest vectored request, rising-edge latched |
| req_trap | input | 1 | Non-maskable trap request, edge and level |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| slot_end | input | 1 | Instruction boundary sample strobe |
| data_in | input | 8 | Data bus, read during acknowledge |
| ack_o | output | 1 | Interrupt acknowledge strobe |
| push_req | output | 1 | Request to push the return address and jump to the vector |
| vec_addr | output | 16 | Vector address, valid with push_req |
| int_en | output | 1 | State of the interrupt-enable flip-flop |
| op_err | output | 1 | Malformed restart opcode flag, valid with push_req |

## Verification
A stuck or wrongly updated enable flip-flop shows up on `int_en` one clock after the strobe or acceptance that should have changed it. A maskable request taken or refused wrongly then shows up as a wrong `push_req` or `ack_o` in the very next cycle. A wrong priority choice or a mis-decoded opcode appears as a wrong `vec_addr` in the single `push_req` cycle, at most two cycles after the boundary. A stored edge that is not cleared, or one that is lost, is only exposed at the next boundary after the enable flip-flop is set again. For that reason the sweeps reset between cases and the directed tests probe a second boundary on purpose.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_TRAP,
    SRC_VHI,
    SRC_VMID,
    SRC_VLO,
    SRC_GEN
  } irq_src_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACK,
    ST_PUSH
  } seq_st_e;

  // A well-formed restart byte has ones in the top two and bottom three bits.
  function automatic logic op_well_formed(input logic [7:0] op);
    return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
  endfunction

  // Slot number carried by the byte; a malformed byte maps to slot 7.
  function automatic logic [2:0] op_slot(input logic [7:0] op);
    return op_well_formed(op) ? op[5:3] : 3'd7;
  endfunction

  // Each restart slot owns eight bytes of the low vector area.
  function automatic logic [5:0] slot_offset(input logic [2:0] n);
    return {n, 3'b000};
  endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit NEED_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic take,
  output logic pend
);

  logic prev_q;
  logic pend_q;
  logic rise;
  logic drop;

  assign rise = lvl & ~prev_q;

  generate
    if (NEED_LEVEL) begin : g_level_kept
      assign drop = ~lvl;
    end else begin : g_sticky
      assign drop = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (take) begin
        pend_q <= 1'b0;
      end else if (rise) begin
        pend_q <= 1'b1;
      end else if (drop) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/irq_ie_flop.sv
module irq_ie_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic kill,
  output logic ie
);

  logic ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else if (kill || clr_stb) begin
      ie_q <= 1'b0;
    end else if (set_stb) begin
      ie_q <= 1'b1;
    end
  end

  assign ie = ie_q;

endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_pkg::*;
(
  input  logic     ie,
  input  logic     trap_rdy,
  input  logic     vhi_rdy,
  input  logic     vmid_rdy,
  input  logic     vlo_rdy,
  input  logic     gen_rdy,
  output irq_src_e win
);

  always_comb begin
    if (trap_rdy) begin
      win = SRC_TRAP;
    end else if (!ie) begin
      win = SRC_NONE;
    end else if (vhi_rdy) begin
      win = SRC_VHI;
    end else if (vmid_rdy) begin
      win = SRC_VMID;
    end else if (vlo_rdy) begin
      win = SRC_VLO;
    end else if (gen_rdy) begin
      win = SRC_GEN;
    end else begin
      win = SRC_NONE;
    end
  end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] VEC_TRAP = 'h24,
  parameter logic [ADDR_W-1:0] VEC_VHI  = 'h3C,
  parameter logic [ADDR_W-1:0] VEC_VMID = 'h34,
  parameter logic [ADDR_W-1:0] VEC_VLO  = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_end,
  input  irq_src_e          win,
  input  logic [DATA_W-1:0] data_in,
  output logic              accept,
  output logic              ack_o,
  output logic              push_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              op_err
);

  seq_st_e           st_q;
  logic [ADDR_W-1:0] vec_q;
  logic              bad_q;
  logic [ADDR_W-1:0] fixed_vec;
  logic [7:0]        op_byte;

  assign op_byte = data_in[7:0];
  assign accept  = (st_q == ST_IDLE) && slot_end && (win != SRC_NONE);

  always_comb begin
    case (win)
      SRC_TRAP: fixed_vec = VEC_TRAP;
      SRC_VHI:  fixed_vec = VEC_VHI;
      SRC_VMID: fixed_vec = VEC_VMID;
      SRC_VLO:  fixed_vec = VEC_VLO;
      default:  fixed_vec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      vec_q <= '0;
      bad_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (win == SRC_GEN) begin
              st_q <= ST_ACK;
            end else begin
              st_q  <= ST_PUSH;
              vec_q <= fixed_vec;
              bad_q <= 1'b0;
            end
          end
        end
        ST_ACK: begin
          vec_q <= ADDR_W'(slot_offset(op_slot(op_byte)));
          bad_q <= ~op_well_formed(op_byte);
          st_q  <= ST_PUSH;
        end
        ST_PUSH: begin
          st_q <= ST_IDLE;
        end
        default: begin
          st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign ack_o    = (st_q == ST_ACK);
  assign push_req = (st_q == ST_PUSH);
  assign vec_addr = vec_q;
  assign op_err   = push_req & bad_q;

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_gen,
  input  logic              req_vlo,
  input  logic              req_vmid,
  input  logic              req_vhi,
  input  logic              req_trap,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              slot_end,
  input  logic [DATA_W-1:0] data_in,
  output logic              ack_o,
  output logic              push_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              int_en,
  output logic              op_err
);

  logic     ie;
  logic     accept;
  irq_src_e win;
  logic     vhi_pend;
  logic     trap_pend;
  logic     take_vhi;
  logic     take_trap;
  logic     trap_rdy;

  assign take_vhi  = accept && (win == SRC_VHI);
  assign take_trap = accept && (win == SRC_TRAP);
  assign trap_rdy  = trap_pend & req_trap;

  irq_edge_latch #(.NEED_LEVEL(1'b0)) u_vhi_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (req_vhi),
    .take  (take_vhi),
    .pend  (vhi_pend)
  );

  irq_edge_latch #(.NEED_LEVEL(1'b1)) u_trap_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (req_trap),
    .take  (take_trap),
    .pend  (trap_pend)
  );

  irq_ie_flop u_ie (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (ei_stb),
    .clr_stb (di_stb),
    .kill    (accept),
    .ie      (ie)
  );

  irq_prio u_prio (
    .ie       (ie),
    .trap_rdy (trap_rdy),
    .vhi_rdy  (vhi_pend),
    .vmid_rdy (req_vmid),
    .vlo_rdy  (req_vlo),
    .gen_rdy  (req_gen),
    .win      (win)
  );

  irq_seq_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_end (slot_end),
    .win      (win),
    .data_in  (data_in),
    .accept   (accept),
    .ack_o    (ack_o),
    .push_req (push_req),
    .vec_addr (vec_addr),
    .op_err   (op_err)
  );

  assign int_en = ie;

endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input irq_src_e          win,
  input logic              ie,
  input logic              ei_stb,
  input logic              di_stb,
  input logic              req_trap,
  input logic              ack_o,
  input logic              push_req,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              op_err
);

  assert_ei_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_stb && !di_stb && !accept) |=> ie);

  assert_di_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    di_stb |=> !ie);

  assert_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (win != SRC_TRAP)) |-> ie);

  assert_accept_clears_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ie);

  assert_gen_acks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (win == SRC_GEN)) |=> ack_o);

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> (!ack_o && push_req));

  assert_bad_op_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> (push_req && (vec_addr == ADDR_W'('h38))));

  assert_fixed_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (win != SRC_GEN)) |=> (push_req && !ack_o));

  assert_trap_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (win == SRC_TRAP)) |-> req_trap);

  assert_push_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> !push_req);

  assert_busy_no_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o || push_req) |-> !accept);

endmodule

bind irq_ack_seq irq_ack_chk #(.ADDR_W(ADDR_W)) u_irq_ack_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .win      (win),
  .ie       (ie),
  .ei_stb   (ei_stb),
  .di_stb   (di_stb),
  .req_trap (req_trap),
  .ack_o    (ack_o),
  .push_req (push_req),
  .vec_addr (vec_addr),
  .op_err   (op_err)
);

// File: tb/test_irq_ack_seq.sv
module test_irq_ack_seq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_gen, req_vlo, req_vmid, req_vhi, req_trap;
  logic        ei_stb, di_stb, slot_end;
  logic [7:0]  data_in;
  logic        ack_o, push_req, int_en, op_err;
  logic [15:0] vec_addr;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_P / 2) clk = ~clk;

  irq_ack_seq i_irq_ack_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_gen  (req_gen),
    .req_vlo  (req_vlo),
    .req_vmid (req_vmid),
    .req_vhi  (req_vhi),
    .req_trap (req_trap),
    .ei_stb   (ei_stb),
    .di_stb   (di_stb),
    .slot_end (slot_end),
    .data_in  (data_in),
    .ack_o    (ack_o),
    .push_req (push_req),
    .vec_addr (vec_addr),
    .int_en   (int_en),
    .op_err   (op_err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_gen = 0; req_vlo = 0; req_vmid = 0; req_vhi = 0; req_trap = 0;
    ei_stb = 0; di_stb = 0; slot_end = 0; data_in = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic enable_ints();
    ei_stb = 1'b1;
    tick();
    ei_stb = 1'b0;
  endtask

  task automatic boundary();
    slot_end = 1'b1;
    tick();
    slot_end = 1'b0;
  endtask

  // Expected target for a bus byte, derived from the slot arithmetic.
  function automatic int exp_gen_vec(input int op);
    if ((op / 64) == 3 && (op % 8) == 7) return ((op / 8) % 8) * 8;
    return 56;
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    // R1: state after reset
    check(!ack_o && !push_req && !op_err, "R1 outputs idle", {ack_o, push_req, op_err}, 0);
    check(int_en == 1'b0, "R1 enable clear", int_en, 0);

    // R1: a stored high-vector edge does not survive reset
    req_vhi = 1; tick(); req_vhi = 0; tick();
    rst_n = 0; tick(); rst_n = 1; tick();
    enable_ints();
    boundary();
    check(!push_req && !ack_o, "R1 edge forgotten", push_req, 0);

    // R2: set, clear, simultaneous
    do_reset();
    enable_ints();
    check(int_en == 1'b1, "R2 ei sets", int_en, 1);
    di_stb = 1; tick(); di_stb = 0;
    check(int_en == 1'b0, "R2 di clears", int_en, 0);
    ei_stb = 1; di_stb = 1; tick(); ei_stb = 0; di_stb = 0;
    check(int_en == 1'b0, "R2 di wins", int_en, 0);

    // R4: no evaluation without the boundary strobe
    do_reset();
    enable_ints();
    req_vlo = 1;
    for (int k = 0; k < 5; k++) begin
      tick();
      check(!push_req && !ack_o, "R4 no boundary no take", push_req, 0);
      check(int_en == 1'b1, "R4 enable held", int_en, 1);
    end
    boundary();
    check(push_req && vec_addr == 16'h002C, "R4 take at boundary", vec_addr, 16'h002C);
    check(int_en == 1'b0, "R4 take clears enable", int_en, 0);
    req_vlo = 0; tick();

    // R5, R6: sweep every bus byte through the general path
    for (int op = 0; op < 256; op++) begin
      do_reset();
      enable_ints();
      req_gen = 1;
      boundary();
      req_gen = 0;
      check(ack_o && !push_req, $sformatf("R5 ack op=%0h", op), ack_o, 1);
      check(int_en == 1'b0, "R4 enable cleared", int_en, 0);
      data_in = 8'(op);
      tick();
      data_in = 8'h00;
      check(push_req && !ack_o, $sformatf("R5 push op=%0h", op), push_req, 1);
      check(vec_addr == 16'(exp_gen_vec(op)), $sformatf("R5 R6 vector op=%0h", op),
            vec_addr, exp_gen_vec(op));
      check(op_err == (exp_gen_vec(op) == 56 && op != 255), $sformatf("R6 flag op=%0h", op),
            op_err, (exp_gen_vec(op) == 56 && op != 255));
      tick();
      check(!push_req && !op_err, "R11 push ends", push_req, 0);
    end

    // R3, R7, R8: every request combination with enable on and off
    for (int m = 0; m < 64; m++) begin
      int exp_v;
      bit ie_on;
      ie_on = m[5];
      do_reset();
      if (ie_on) enable_ints();
      req_trap = m[4]; req_vhi = m[3]; req_vmid = m[2]; req_vlo = m[1]; req_gen = m[0];
      tick();
      boundary();
      if (m[4])           exp_v = 16'h0024;
      else if (!ie_on)    exp_v = -1;
      else if (m[3])      exp_v = 16'h003C;
      else if (m[2])      exp_v = 16'h0034;
      else if (m[1])      exp_v = 16'h002C;
      else if (m[0])      exp_v = -2;
      else                exp_v = -1;
      if (exp_v == -1) begin
        check(!push_req && !ack_o, $sformatf("R3 none m=%0d", m), push_req, 0);
        check(int_en == ie_on, $sformatf("R3 enable kept m=%0d", m), int_en, ie_on);
      end else if (exp_v == -2) begin
        check(ack_o && !push_req, $sformatf("R8 gen ack m=%0d", m), ack_o, 1);
        data_in = 8'hD7; tick(); data_in = 8'h00;
        check(push_req && vec_addr == 16'h0010, $sformatf("R5 gen vec m=%0d", m),
              vec_addr, 16'h0010);
      end else begin
        check(push_req && !ack_o && vec_addr == 16'(exp_v),
              $sformatf("R7 R8 fixed m=%0d", m), vec_addr, exp_v);
        check(int_en == 1'b0, $sformatf("R4 cleared m=%0d", m), int_en, 0);
      end
      idle_inputs();
      tick();
    end

    // R9: stored edge waits for enable, then clears on service
    do_reset();
    req_vhi = 1; tick(); req_vhi = 0; tick();
    boundary();
    check(!push_req, "R9 masked while disabled", push_req, 0);
    enable_ints();
    boundary();
    check(push_req && vec_addr == 16'h003C, "R9 held edge serviced", vec_addr, 16'h003C);
    tick();
    enable_ints();
    boundary();
    check(!push_req && !ack_o, "R9 edge cleared", push_req, 0);

    // R10: pulsed trap gone before boundary
    do_reset();
    req_trap = 1; tick(); req_trap = 0; tick();
    boundary();
    check(!push_req, "R10 dropped trap ignored", push_req, 0);
    // R10: held trap taken once
    req_trap = 1; tick();
    boundary();
    check(push_req && vec_addr == 16'h0024, "R10 trap taken", vec_addr, 16'h0024);
    tick(); tick();
    boundary();
    check(!push_req && !ack_o, "R10 no second take", push_req, 0);
    req_trap = 0; tick();

    // R11: boundary and request held through a running sequence
    do_reset();
    enable_ints();
    req_gen = 1; slot_end = 1;
    tick();
    check(ack_o, "R11 ack starts", ack_o, 1);
    data_in = 8'hFF; tick();
    check(push_req && vec_addr == 16'h0038 && !op_err, "R11 push once", vec_addr, 16'h0038);
    tick();
    check(!push_req && !ack_o, "R11 no retake while disabled", push_req, 0);
    idle_inputs();
    tick();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule